// File: doc/BRIEF.md
# Delayed Branch Sequencer with Link

This block holds the program counter and the branch control of a small in-order core whose branches carry one delay slot. Each cycle it is given a decoded descriptor for the instruction at the current fetch address. The descriptor says whether the instruction branches, whether it links, the condition outcome, where the target comes from (an immediate or a register), and whether the delay slot is annulled or skipped. From this the block produces the next fetch address and an execute-enable that qualifies the current instruction.

The block keeps the core's 16-entry register file. Target reads, link writes and delay-slot writes then happen in a fixed order. The target and the condition are captured when the branch executes. The link value is written in that same cycle. The slot instruction comes next, and its result, supplied on an external ALU write port, lands on top of the link or target register. Only after the slot does the fetch address jump. A stall input freezes the whole sequence.

Top module: `dslot_seq`

## Requirements
- R1: After synchronous reset, fetch_pc is 0, exec_en is 1 and slot_err is 0.
- R2: Each unstalled cycle that holds no branch and no pending redirect advances fetch_pc by 4 bytes.
- R3: The register file has 16 entries of 32 bits. It is written by wr_en/wr_reg/wr_data and read combinationally on rd_reg/rd_data. Entry 0 always reads 0 and ignores writes. Entry 1 is the link register.
- R4: With no annul and no skip, the instruction at branch address A+4 always executes (exec_en=1). The fetch address that follows it is the target if the branch is taken, and A+8 if not.
- R5: A register target is read in the branch cycle. A write to that register by the slot instruction does not change the jump, and the new value is readable after the jump.
- R6: A taken branch with is_link writes A+8 into entry 1 during the branch cycle. A write to entry 1 by the slot instruction overrides it. A branch that is not taken leaves entry 1 unchanged.
- R7: With annul set, the slot executes only if the branch is taken. Otherwise exec_en is 0 in the slot, its write is dropped, and fetch continues at A+8.
- R8: With skip set, the cycle after the branch is a bubble: fetch_pc is A+4, exec_en is 0 and the descriptor is ignored. The next fetch address is then the target if taken, or A+4 again if not. A linking skip branch writes A+4 into entry 1.
- R9: A branch descriptor in an executing delay slot does nothing: no capture, no link and no redirect. It sets slot_err, which stays at 1 until reset.
- R10: While stall is 1, fetch_pc, exec_en, the pending branch state and the register file all hold. The captured target survives the stall.
- R11: A suppressed cycle (annulled slot or bubble) writes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freeze sequencer and register writes |
| is_br | input | 1 | Descriptor: instruction is a branch |
| is_link | input | 1 | Descriptor: branch writes the link register |
| cond | input | 1 | Descriptor: branch condition outcome (1 = taken) |
| tgt_sel | input | 1 | Descriptor: 0 = immediate target, 1 = register target |
| annul | input | 1 | Descriptor: slot runs only when taken |
| skip | input | 1 | Descriptor: no slot, insert a bubble |
| imm_tgt | input | 32 | Immediate branch target |
| tgt_reg | input | 4 | Register holding the branch target |
| wr_en | input | 1 | ALU result write request |
| wr_reg | input | 4 | ALU result destination register |
| wr_data | input | 32 | ALU result |
| rd_reg | input | 4 | Read port address |
| rd_data | output | 32 | Read port data |
| fetch_pc | output | 32 | Next fetch byte address |
| exec_en | output | 1 | Current instruction may execute |
| slot_err | output | 1 | Sticky: branch found in a delay slot |

## Verification
A wrong captured target or a wrong taken flag shows up at fetch_pc on the cycle right after the slot, because the redirect is the only thing that reads them. A wrong write order for the link or the target register shows up on rd_data as soon as the jump has happened, since the slot's write must be the one that remains. A phase register stuck in the wrong state shows up within one cycle, either as an exec_en value that breaks the annul or skip rule, or as a fetch_pc that fails to advance by 4.

// File: rtl/dslot_pkg.sv
package dslot_pkg;
  // Sequencer phase: normal flow, executing/annulled slot, or skip bubble.
  typedef enum logic [1:0] {
    PH_RUN    = 2'd0,
    PH_SLOT   = 2'd1,
    PH_BUBBLE = 2'd2
  } phase_t;
endpackage

// File: rtl/dslot_regfile.sv
module dslot_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  localparam int RIDX = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [RIDX-1:0] waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [RIDX-1:0] ra_addr,
  output logic [XLEN-1:0] ra_data,
  input  logic [RIDX-1:0] rb_addr,
  output logic [XLEN-1:0] rb_data
);
  logic [XLEN-1:0] mem [NREG];

  // Plain write port without reset, so distributed RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) mem[waddr] <= wdata;
  end

  assign ra_data = (ra_addr == '0) ? '0 : mem[ra_addr];
  assign rb_data = (rb_addr == '0) ? '0 : mem[rb_addr];
endmodule

// File: rtl/dslot_ctrl.sv
module dslot_ctrl
  import dslot_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall,
  input  logic            is_br,
  input  logic            is_link,
  input  logic            cond,
  input  logic            tgt_sel,
  input  logic            annul,
  input  logic            skip,
  input  logic [XLEN-1:0] imm_tgt,
  input  logic [XLEN-1:0] reg_tgt,
  output logic [XLEN-1:0] fetch_pc,
  output logic            exec_en,
  output logic            slot_err,
  output phase_t          phase,
  output logic            taken_q,
  output logic [XLEN-1:0] tgt_q,
  output logic            link_we,
  output logic [XLEN-1:0] link_val
);
  localparam logic [XLEN-1:0] STEP  = XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] STEP2 = XLEN'(2 * INSN_BYTES);

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] seq_pc;
  logic            run_br;

  assign seq_pc = pc_q + STEP;
  assign run_br = (phase == PH_RUN) && is_br;

  // Link is written in the branch cycle itself, ahead of the slot.
  assign link_we  = !stall && run_br && is_link && cond;
  assign link_val = skip ? seq_pc : (pc_q + STEP2);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      phase    <= PH_RUN;
      exec_en  <= 1'b1;
      slot_err <= 1'b0;
      taken_q  <= 1'b0;
      tgt_q    <= '0;
    end else if (!stall) begin
      unique case (phase)
        PH_RUN: begin
          pc_q <= seq_pc;
          if (is_br) begin
            tgt_q   <= tgt_sel ? reg_tgt : imm_tgt;
            taken_q <= cond;
            phase   <= skip ? PH_BUBBLE : PH_SLOT;
            exec_en <= !(skip || (annul && !cond));
          end
        end
        PH_SLOT: begin
          if (exec_en && is_br) slot_err <= 1'b1;
          pc_q    <= taken_q ? tgt_q : seq_pc;
          phase   <= PH_RUN;
          exec_en <= 1'b1;
        end
        PH_BUBBLE: begin
          // The skipped word is refetched when the branch falls through.
          pc_q    <= taken_q ? tgt_q : pc_q;
          phase   <= PH_RUN;
          exec_en <= 1'b1;
        end
        default: begin
          phase   <= PH_RUN;
          exec_en <= 1'b1;
        end
      endcase
    end
  end

  assign fetch_pc = pc_q;
endmodule

// File: rtl/dslot_seq.sv
module dslot_seq
  import dslot_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int NREG       = 16,
  parameter int LINK_IDX   = 1,
  parameter int INSN_BYTES = 4,
  localparam int RIDX      = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall,
  input  logic            is_br,
  input  logic            is_link,
  input  logic            cond,
  input  logic            tgt_sel,
  input  logic            annul,
  input  logic            skip,
  input  logic [XLEN-1:0] imm_tgt,
  input  logic [RIDX-1:0] tgt_reg,
  input  logic            wr_en,
  input  logic [RIDX-1:0] wr_reg,
  input  logic [XLEN-1:0] wr_data,
  input  logic [RIDX-1:0] rd_reg,
  output logic [XLEN-1:0] rd_data,
  output logic [XLEN-1:0] fetch_pc,
  output logic            exec_en,
  output logic            slot_err
);
  phase_t          phase;
  logic            taken_q;
  logic [XLEN-1:0] tgt_q;
  logic            link_we;
  logic [XLEN-1:0] link_val;
  logic [XLEN-1:0] reg_tgt;
  logic            alu_we;
  logic            rf_we;
  logic [RIDX-1:0] rf_waddr;
  logic [XLEN-1:0] rf_wdata;

  dslot_ctrl #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_ctrl (
    .clk(clk), .rst(rst), .stall(stall),
    .is_br(is_br), .is_link(is_link), .cond(cond), .tgt_sel(tgt_sel),
    .annul(annul), .skip(skip), .imm_tgt(imm_tgt), .reg_tgt(reg_tgt),
    .fetch_pc(fetch_pc), .exec_en(exec_en), .slot_err(slot_err),
    .phase(phase), .taken_q(taken_q), .tgt_q(tgt_q),
    .link_we(link_we), .link_val(link_val)
  );

  // Branches never write through the ALU port; bubbles are already suppressed.
  assign alu_we   = wr_en && !stall && exec_en && !is_br && (phase != PH_BUBBLE);
  assign rf_we    = link_we || alu_we;
  assign rf_waddr = link_we ? RIDX'(LINK_IDX) : wr_reg;
  assign rf_wdata = link_we ? link_val : wr_data;

  dslot_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra_addr(tgt_reg), .ra_data(reg_tgt),
    .rb_addr(rd_reg), .rb_data(rd_data)
  );
endmodule

// File: rtl/dslot_seq_chk.sv
module dslot_seq_chk
  import dslot_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RIDX = 4,
  parameter int INSN_BYTES = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            stall,
  input logic            is_br,
  input logic [RIDX-1:0] rd_reg,
  input logic [XLEN-1:0] rd_data,
  input logic [XLEN-1:0] fetch_pc,
  input logic            exec_en,
  input logic            slot_err,
  input phase_t          phase,
  input logic            taken_q,
  input logic [XLEN-1:0] tgt_q,
  input logic            rf_we
);
  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    (!stall && phase == PH_RUN && !is_br) |=> fetch_pc == $past(fetch_pc) + XLEN'(INSN_BYTES));

  a_r3_zero_reg: assert property (@(posedge clk) disable iff (rst)
    (rd_reg == '0) |-> (rd_data == '0));

  a_r4_redirect: assert property (@(posedge clk) disable iff (rst)
    (!stall && phase == PH_SLOT && taken_q) |=> fetch_pc == $past(tgt_q));

  a_r8_bubble_off: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_BUBBLE) |-> !exec_en);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    slot_err |=> slot_err);

  a_r10_stall_hold: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(fetch_pc) && $stable(exec_en) && $stable(tgt_q)));

  a_r11_no_write: assert property (@(posedge clk) disable iff (rst)
    (!exec_en || stall) |-> !rf_we);
endmodule

bind dslot_seq dslot_seq_chk #(.XLEN(XLEN), .RIDX(RIDX), .INSN_BYTES(INSN_BYTES)) u_chk (
  .clk(clk), .rst(rst), .stall(stall), .is_br(is_br),
  .rd_reg(rd_reg), .rd_data(rd_data), .fetch_pc(fetch_pc),
  .exec_en(exec_en), .slot_err(slot_err), .phase(phase),
  .taken_q(taken_q), .tgt_q(tgt_q), .rf_we(rf_we)
);

// File: tb/dslot_seq_bench.sv
`timescale 1ns/1ps
module dslot_seq_bench;
  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst, stall, is_br, is_link, cond, tgt_sel, annul, skip, wr_en;
  logic [31:0] imm_tgt, wr_data, rd_data, fetch_pc;
  logic [3:0]  tgt_reg, wr_reg, rd_reg;
  logic        exec_en, slot_err;
  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_NS/2) clk = ~clk;

  dslot_seq u_dslot_seq (
    .clk(clk), .rst(rst), .stall(stall), .is_br(is_br), .is_link(is_link),
    .cond(cond), .tgt_sel(tgt_sel), .annul(annul), .skip(skip),
    .imm_tgt(imm_tgt), .tgt_reg(tgt_reg), .wr_en(wr_en), .wr_reg(wr_reg),
    .wr_data(wr_data), .rd_reg(rd_reg), .rd_data(rd_data),
    .fetch_pc(fetch_pc), .exec_en(exec_en), .slot_err(slot_err)
  );

  task automatic idle();
    stall = 0; is_br = 0; is_link = 0; cond = 0; tgt_sel = 0;
    annul = 0; skip = 0; imm_tgt = '0; tgt_reg = '0;
    wr_en = 0; wr_reg = '0; wr_data = '0;
  endtask

  // Clock edge, then settle; inputs change and outputs are sampled here.
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] r, input string req, input logic [31:0] exp);
    rd_reg = r; #1; chk(req, rd_data, exp);
  endtask

  task automatic wr(input logic [3:0] r, input logic [31:0] d);
    idle(); wr_en = 1; wr_reg = r; wr_data = d;
  endtask

  task automatic br(input logic c, input logic [31:0] t);
    idle(); is_br = 1; cond = c; imm_tgt = t;
  endtask

  task automatic t_reset();
    chk("R1 pc", fetch_pc, 32'h0);
    chk("R1 exec_en", {31'b0, exec_en}, 32'h1);
    chk("R1 slot_err", {31'b0, slot_err}, 32'h0);
  endtask

  task automatic t_regs();
    wr(4'd3, 32'h1234); step();
    rd(4'd3, "R3 write r3", 32'h1234);
    chk("R2 pc+4", fetch_pc, 32'h4);
    wr(4'd0, 32'h5); step();
    rd(4'd0, "R3 r0 zero", 32'h0);
    chk("R2 pc+8", fetch_pc, 32'h8);
  endtask

  task automatic t_taken();
    br(1, 32'h100); step();
    chk("R4 slot pc", fetch_pc, 32'hC);
    chk("R4 slot exec", {31'b0, exec_en}, 32'h1);
    wr(4'd5, 32'h7); step();
    chk("R4 taken redirect", fetch_pc, 32'h100);
    rd(4'd5, "R4 slot write", 32'h7);
    br(0, 32'h500); step();
    chk("R4 not-taken slot pc", fetch_pc, 32'h104);
    idle(); step();
    chk("R4 not-taken A+8", fetch_pc, 32'h108);
  endtask

  task automatic t_regtgt();
    wr(4'd6, 32'h200); step();
    br(1, 32'h0); tgt_sel = 1; tgt_reg = 4'd6; step();
    wr(4'd6, 32'h300); step();
    chk("R5 old target used", fetch_pc, 32'h200);
    rd(4'd6, "R5 new value visible", 32'h300);
  endtask

  task automatic t_link();
    wr(4'd1, 32'hDEAD); step();
    br(0, 32'h40); is_link = 1; step();
    rd(4'd1, "R6 not taken keeps link", 32'hDEAD);
    idle(); step();
    chk("R6 pc", fetch_pc, 32'h20C);
    br(1, 32'h40); is_link = 1; step();
    rd(4'd1, "R6 link A+8", 32'h214);
    wr(4'd1, 32'h214 + 32'h10); step();
    chk("R6 jump", fetch_pc, 32'h40);
    rd(4'd1, "R6 slot overrides link", 32'h224);
  endtask

  task automatic t_annul();
    wr(4'd7, 32'h5A); step();
    br(1, 32'h80); annul = 1; step();
    chk("R7 taken slot exec", {31'b0, exec_en}, 32'h1);
    wr(4'd7, 32'h11); step();
    rd(4'd7, "R7 taken slot writes", 32'h11);
    chk("R7 taken pc", fetch_pc, 32'h80);
    br(0, 32'h900); annul = 1; step();
    chk("R7 annulled exec", {31'b0, exec_en}, 32'h0);
    wr(4'd7, 32'h22); step();
    rd(4'd7, "R11 annulled no write", 32'h11);
    chk("R7 annulled pc A+8", fetch_pc, 32'h88);
  endtask

  task automatic t_skip();
    br(1, 32'h300); skip = 1; is_link = 1; step();
    chk("R8 bubble exec", {31'b0, exec_en}, 32'h0);
    chk("R8 bubble pc", fetch_pc, 32'h8C);
    rd(4'd1, "R8 link A+4", 32'h8C);
    wr(4'd7, 32'h33); is_br = 1; cond = 1; imm_tgt = 32'h999; step();
    chk("R8 skip redirect", fetch_pc, 32'h300);
    rd(4'd7, "R11 bubble no write", 32'h11);
    chk("R8 bubble branch ignored", {31'b0, slot_err}, 32'h0);
    br(0, 32'h700); skip = 1; step();
    chk("R8 nt bubble pc", fetch_pc, 32'h304);
    idle(); step();
    chk("R8 nt refetch A+4", fetch_pc, 32'h304);
    chk("R8 nt exec", {31'b0, exec_en}, 32'h1);
    step();
    chk("R2 after skip", fetch_pc, 32'h308);
  endtask

  task automatic t_stall();
    wr(4'd8, 32'h55); step();
    br(1, 32'h600); step();
    wr(4'd8, 32'h44); stall = 1; step(); step();
    chk("R10 pc held", fetch_pc, 32'h310);
    chk("R10 exec held", {31'b0, exec_en}, 32'h1);
    rd(4'd8, "R10 no write", 32'h55);
    idle(); step();
    chk("R10 target kept", fetch_pc, 32'h600);
  endtask

  task automatic t_slotbr();
    br(1, 32'h700); step();
    br(1, 32'h999); is_link = 1; step();
    chk("R9 slot branch ignored", fetch_pc, 32'h700);
    chk("R9 err set", {31'b0, slot_err}, 32'h1);
    rd(4'd1, "R9 no link", 32'h8C);
    idle(); step();
    chk("R9 err sticky", {31'b0, slot_err}, 32'h1);
    chk("R9 pc", fetch_pc, 32'h704);
  endtask

  initial begin
    idle(); rd_reg = '0; rst = 1;
    step(); step();
    rst = 0;
    t_reset();
    t_regs();
    t_taken();
    t_regtgt();
    t_link();
    t_annul();
    t_skip();
    t_stall();
    t_slotbr();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule